// File: doc/BRIEF.md
# Phase-Error Lock Watcher

This block sits beside a phase-frequency comparator and turns its raw pump-up and pump-down pulses into a single lock indication. Both comparator outputs pass through a polarity selector that can exchange them before they reach the charge pump. The same pulses are sampled once per crystal clock cycle. Any single phase-error pulse that stays active for more crystal cycles than the chosen window counts as a loss of lock. The decision is made pulse by pulse and is never averaged over time.

When loss of lock is seen, the flag is held in the unlocked state. It stays there until a selectable number of reference-rate strobes have passed with no further violation. Any new violation starts that count again. After reset the flag reads unlocked and clears only after one full extension period. The flag is active low: it is driven low while the loop is locked and released high while it is unlocked.

Top module: `lock_watch`

## Requirements
- R1: With `swap_pol` = 0, `up_out` equals `up_raw` and `dn_out` equals `dn_raw`.
- R2: With `swap_pol` = 1, `up_out` equals `dn_raw` and `dn_out` equals `up_raw`.
- R3: With `long_win` = 0, an error pulse (`up_raw` or `dn_raw` high) sampled on at most 4 consecutive clock edges leaves the lock state unchanged. A pulse sampled on 5 or more edges sets `lock_n` high.
- R4: With `long_win` = 1, a pulse of at most 8 sampled edges leaves the lock state unchanged. A pulse of 9 or more edges sets `lock_n` high.
- R5: The pulse-width count clears on any clock edge where both inputs were sampled low. It saturates and does not wrap, so short pulses separated by single low cycles never add up to an unlock.
- R6: Once unlocked, `lock_n` returns low on the `ref_tick` edge that completes 4, 8, 16 or 32 strobes for `ext_sel` = 0, 1, 2 or 3 respectively. It does not change on any edge without a strobe.
- R7: A violation during an active extension restarts the strobe count from zero.
- R8: While an over-length pulse continues, strobes do not release the flag. The count starts only after the violation ends.
- R9: During reset and after it, `lock_n` is high until one full extension period of strobes has passed.
- R10: `lock_n` low means locked and high means unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-rate clock that samples the comparator pulses |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe at the reference rate |
| up_raw | input | 1 | Comparator pump-up pulse |
| dn_raw | input | 1 | Comparator pump-down pulse |
| swap_pol | input | 1 | Exchanges the up and down outputs when high |
| long_win | input | 1 | Selects the long error window (8 cycles) instead of the short one (4) |
| ext_sel | input | 2 | Extension length select: 4 << ext_sel strobes |
| up_out | output | 1 | Pump-up after polarity selection |
| dn_out | output | 1 | Pump-down after polarity selection |
| lock_n | output | 1 | Active-low lock flag |

## Verification
The bench builds the block with its defaults: windows of 4 and 8 cycles and an extension base of 4 strobes. With these values the exact boundary widths 4/5 and 8/9 can be driven directly, and every extension length up to 32 strobes fits in a short run. A vector table covers both polarities, both windows and both input lines at the boundary widths. Directed tests then cover the reset release, each extension length, a restart during an extension, an over-length pulse with strobes present, and a train of trains of threshold-width pulses.

// File: rtl/lock_watch.sv
module lock_watch #(
  parameter int THR_SHORT = 4,
  parameter int THR_LONG  = 8,
  parameter int EXT_BASE  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       up_raw,
  input  logic       dn_raw,
  input  logic       swap_pol,
  input  logic       long_win,
  input  logic [1:0] ext_sel,
  output logic       up_out,
  output logic       dn_out,
  output logic       lock_n
);
  localparam int WW   = $clog2(THR_LONG + 1);
  localparam int EMAX = EXT_BASE * 8;
  localparam int EW   = $clog2(EMAX);

  logic          err_q;
  logic [WW-1:0] wcnt;
  logic [WW-1:0] lim;
  logic [EW-1:0] ecnt;
  logic [EW:0]   tgt;
  logic          viol;
  logic          last_tick;

  // polarity selection
  assign up_out = swap_pol ? dn_raw : up_raw;
  assign dn_out = swap_pol ? up_raw : dn_raw;

  assign lim       = long_win ? WW'(THR_LONG) : WW'(THR_SHORT);
  assign tgt       = (EW+1)'(EXT_BASE) << ext_sel;
  assign viol      = err_q && (wcnt >= lim);
  assign last_tick = ({1'b0, ecnt} == tgt - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      wcnt  <= '0;
    end else begin
      err_q <= up_raw | dn_raw;
      if (!err_q)          wcnt <= '0;
      else if (wcnt >= lim) wcnt <= lim;
      else                 wcnt <= wcnt + 1'b1;
    end
  end

  // lock_n high = unlocked (released), low = locked
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_n <= 1'b1;
      ecnt   <= '0;
    end else if (viol) begin
      lock_n <= 1'b1;
      ecnt   <= '0;
    end else if (lock_n && ref_tick) begin
      if (last_tick) begin
        lock_n <= 1'b0;
        ecnt   <= '0;
      end else begin
        ecnt <= ecnt + 1'b1;
      end
    end
  end

  p_unlock_on_viol_r3: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> lock_n);
  p_clear_on_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !err_q |=> (wcnt == '0));
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= WW'(THR_LONG));
  p_hold_no_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_n && !ref_tick) |=> lock_n);
  p_release_on_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_n) |-> $past(ref_tick));
  p_no_release_in_error_r8: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> !$fell(lock_n));
endmodule

// File: tb/test_lock_watch.sv
`timescale 1ns/1ps
module test_lock_watch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_tick = 1'b0;
  logic up_raw = 1'b0;
  logic dn_raw = 1'b0;
  logic swap_pol = 1'b0;
  logic long_win = 1'b0;
  logic [1:0] ext_sel = 2'd0;
  logic up_out, dn_out, lock_n;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lock_watch i_lock_watch (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .up_raw(up_raw),
    .dn_raw(dn_raw), .swap_pol(swap_pol), .long_win(long_win),
    .ext_sel(ext_sel), .up_out(up_out), .dn_out(dn_out), .lock_n(lock_n)
  );

  // {swap, long, use_dn, width[4:0], expect_unlock}
  localparam logic [8:0] VEC [10] = '{
    {1'b0, 1'b0, 1'b0, 5'd4, 1'b0},
    {1'b0, 1'b0, 1'b0, 5'd5, 1'b1},
    {1'b1, 1'b0, 1'b0, 5'd3, 1'b0},
    {1'b1, 1'b0, 1'b1, 5'd5, 1'b1},
    {1'b0, 1'b1, 1'b0, 5'd8, 1'b0},
    {1'b0, 1'b1, 1'b1, 5'd9, 1'b1},
    {1'b1, 1'b1, 1'b0, 5'd9, 1'b1},
    {1'b0, 1'b1, 1'b0, 5'd6, 1'b0},
    {1'b0, 1'b0, 1'b1, 5'd1, 1'b0},
    {1'b1, 1'b1, 1'b1, 5'd8, 1'b0}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic pulse(input logic u, input logic d, input int w);
    @(negedge clk);
    up_raw = u;
    dn_raw = d;
    repeat (w) @(negedge clk);
    up_raw = 1'b0;
    dn_raw = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 in reset", lock_n, 1'b1);
    rst_n = 1'b1;
    tick(3);
    chk("R9 before full extension", lock_n, 1'b1);
    tick(1);
    chk("R9/R10 locked after extension", lock_n, 1'b0);

    for (int i = 0; i < 10; i++) begin
      logic sw, lw, ud, ex;
      int w;
      sw = VEC[i][8]; lw = VEC[i][7]; ud = VEC[i][6];
      w = int'(VEC[i][5:1]); ex = VEC[i][0];
      swap_pol = sw; long_win = lw; ext_sel = 2'd0;
      @(negedge clk);
      up_raw = !ud; dn_raw = ud;
      #1;
      chk(sw ? "R2 up_out" : "R1 up_out", up_out, sw ? ud : !ud);
      chk(sw ? "R2 dn_out" : "R1 dn_out", dn_out, sw ? !ud : ud);
      repeat (w) @(negedge clk);
      up_raw = 1'b0; dn_raw = 1'b0;
      repeat (2) @(negedge clk);
      chk(lw ? "R4 window" : "R3 window", lock_n, ex);
      if (ex) begin
        tick(4);
        chk("R6 recover ext 4", lock_n, 1'b0);
      end
    end

    swap_pol = 1'b0; long_win = 1'b0;
    for (int s = 0; s < 4; s++) begin
      ext_sel = 2'(s);
      pulse(1'b1, 1'b0, 6);
      repeat (2) @(negedge clk);
      tick((4 << s) - 1);
      chk("R6 held one strobe short", lock_n, 1'b1);
      tick(1);
      chk("R6 released on last strobe", lock_n, 1'b0);
    end

    ext_sel = 2'd0;
    pulse(1'b0, 1'b1, 6);
    repeat (2) @(negedge clk);
    tick(3);
    pulse(1'b1, 1'b0, 7);
    repeat (2) @(negedge clk);
    tick(3);
    chk("R7 restarted count", lock_n, 1'b1);
    tick(1);
    chk("R7 release after restart", lock_n, 1'b0);

    for (int k = 0; k < 6; k++) pulse(1'b1, 1'b0, 4);
    repeat (2) @(negedge clk);
    chk("R5 pulse train stays locked", lock_n, 1'b0);

    long_win = 1'b1;
    for (int k = 0; k < 5; k++) pulse(1'b0, 1'b1, 8);
    repeat (2) @(negedge clk);
    chk("R5 long train stays locked", lock_n, 1'b0);
    long_win = 1'b0;

    @(negedge clk);
    ref_tick = 1'b1;
    pulse(1'b1, 1'b0, 40);
    ref_tick = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 no release during error", lock_n, 1'b1);
    tick(4);
    chk("R8 release after error ends", lock_n, 1'b0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule